// File: doc/BRIEF.md
# I2C Controller FIFO Status and Interrupt Unit

This unit sits between a processor-facing register port and the bus sequencer of an I2C controller. It holds two first-in first-out buffers: one for outgoing command words (a data byte, a direction flag, a stop request and a repeated-start request, eleven bits in all) and one for bytes received from the bus. Software pushes commands by writing the command register. The sequencer takes them from a head-of-queue output. The sequencer pushes received bytes, and software pops them by reading the receive register.

The unit watches both buffer levels against programmable thresholds. It records underflow and overflow accesses as separate sticky flags per buffer, and turns these conditions plus the sequencer's done and error pulses into five interrupt sources. Each source has an enable bit (1 enables it). The two event sources are latched and cleared by writing ones. The three condition sources follow their condition. A single interrupt line is the OR of the enabled pending sources.

Each buffer has a flush control. While its bit is set, that buffer is held empty and its error flags are held clear. Software writes the bit back to zero to release it.

Top module: `xfer_fifo_irq`

## Requirements
- R1: After reset the buffer control register reads 0x1F0 (transmit threshold 1 in bits 13:8, receive threshold 60 in bits 7:2, both flush bits 0), the buffer state reads 0x008, the enable register reads 0, and `irq` is 0.
- R2: Command words leave at `seq_tx_cmd` in the order they were written to the command register (word address 0, bits 10:0). Received bytes read from the receive register (address 1, bits 7:0) in the order the sequencer pushed them. Each buffer holds 64 entries.
- R3: Buffer state register (address 3) bit 11 is 1 exactly when the transmit buffer holds 64 entries. Bit 3 is 1 exactly when the receive buffer is empty.
- R4: Writing a command to a full transmit buffer sets state bit 7. Popping an empty transmit buffer sets bit 6. Pushing into a full receive buffer sets bit 1. Reading the receive register while it is empty sets bit 0. In every such case the access is discarded and the buffer contents stay as they were.
- R5: Control bit 1 (transmit) and bit 0 (receive) are level flushes. While one is set, its buffer empties, ignores pushes, and its two error flags read 0. Both bits read back as written.
- R6: Pending bit 4 is 1 while the transmit level is at or below control bits 13:8. Pending bit 3 is 1 while the receive level is at or above control bits 7:2. Each takes effect one cycle after the level changes.
- R7: A pulse on `seq_done` sets pending bit 0 and a pulse on `seq_err` sets pending bit 1. Both stay set until cleared. An event in the same cycle as its clear leaves the bit set.
- R8: Writing the clear register (address 5) clears exactly the written-one bits among pending bits 1:0. Pending bits 4:2 follow their conditions, so a clear does not remove them.
- R9: The masked register (address 6) reads the raw pending register (address 7) ANDed with the enable register (address 4), and `irq` is 1 exactly when the masked value is nonzero.
- R10: Pending bit 2 is 1 one cycle after any of the four buffer error flags is 1.
- R11: The control register (address 2) reads back the threshold and flush fields as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe (pops the receive buffer at address 1) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| seq_tx_cmd | output | 11 | Head of the transmit command buffer |
| seq_tx_valid | output | 1 | Transmit buffer not empty |
| seq_tx_pop | input | 1 | Sequencer takes the head command |
| seq_rx_push | input | 1 | Sequencer pushes a received byte |
| seq_rx_data | input | 8 | Received byte |
| seq_done | input | 1 | Transfer-complete pulse |
| seq_err | input | 1 | Transfer-error pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that each strobe lasts one cycle per access, that `seq_done` and `seq_err` are single-cycle pulses, and that register strobes are only raised with a defined address. The stimulus drives every strobe for exactly one clock. It raises reads and writes only at the documented word addresses. It deliberately presses on the full and empty edges only at the points where an error flag is expected, so that each flag's cause is known when it is checked.

// File: rtl/xfer_fifo_pkg.sv
package xfer_fifo_pkg;

    localparam int ADDR_W     = 3;
    localparam int THR_W      = 6;
    localparam int N_EVT      = 2;
    localparam int N_LVL      = 3;
    localparam int N_SRC      = N_EVT + N_LVL;
    localparam int RST_RX_THR = 60;
    localparam int RST_TX_THR = 1;

    typedef enum logic [ADDR_W-1:0] {
        RA_CMD   = 3'd0,
        RA_RXD   = 3'd1,
        RA_FCTL  = 3'd2,
        RA_FSTAT = 3'd3,
        RA_IEN   = 3'd4,
        RA_ICLR  = 3'd5,
        RA_IMSK  = 3'd6,
        RA_IRAW  = 3'd7
    } reg_addr_e;

    // control register image, packed so that bit positions match the map
    typedef struct packed {
        logic [THR_W-1:0] tx_thr;
        logic [THR_W-1:0] rx_thr;
        logic             tx_flush;
        logic             rx_flush;
    } fctl_t;

endpackage

// File: rtl/xfer_fifo_buf.sv
module xfer_fifo_buf #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       wr_en,
    input  logic [WIDTH-1:0]           wr_data,
    input  logic                       rd_en,
    output logic [WIDTH-1:0]           rd_data,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       empty,
    output logic                       full,
    output logic                       rd_err,
    output logic                       wr_err
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [LW-1:0] cnt;
        logic          rerr;
        logic          werr;
    } buf_st_t;

    buf_st_t state_d, state_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_wr, do_rd;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full  = (state_q.cnt == LW'(DEPTH));
    assign empty = (state_q.cnt == '0);
    assign do_wr = wr_en && !full && !flush;
    assign do_rd = rd_en && !empty && !flush;

    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = '0;
        end else begin
            if (wr_en && full)  state_d.werr = 1'b1;
            if (rd_en && empty) state_d.rerr = 1'b1;
            if (do_wr) state_d.wptr = step(state_q.wptr);
            if (do_rd) state_d.rptr = step(state_q.rptr);
            state_d.cnt = state_q.cnt + LW'(do_wr) - LW'(do_rd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[state_q.wptr] <= wr_data;
    end

    assign rd_data = mem[state_q.rptr];
    assign level   = state_q.cnt;
    assign rd_err  = state_q.rerr;
    assign wr_err  = state_q.werr;

endmodule

// File: rtl/xfer_irq_ctrl.sv
module xfer_irq_ctrl #(
    parameter int N_EVT = 2,
    parameter int N_LVL = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_EVT-1:0]       evt_set,
    input  logic [N_LVL-1:0]       lvl_src,
    input  logic                   en_wr,
    input  logic [N_EVT+N_LVL-1:0] en_wdata,
    input  logic                   clr_wr,
    input  logic [N_EVT+N_LVL-1:0] clr_wdata,
    output logic [N_EVT+N_LVL-1:0] pend,
    output logic [N_EVT+N_LVL-1:0] enable,
    output logic [N_EVT+N_LVL-1:0] masked,
    output logic                   irq
);
    localparam int NS = N_EVT + N_LVL;

    typedef struct packed {
        logic [NS-1:0] pend;
        logic [NS-1:0] en;
    } irq_st_t;

    irq_st_t state_d, state_q;
    logic [N_EVT-1:0] clr_evt;

    assign clr_evt = clr_wr ? clr_wdata[N_EVT-1:0] : '0;

    always_comb begin
        state_d = state_q;
        // latched event sources: set wins over a clear in the same cycle
        state_d.pend[N_EVT-1:0] = (state_q.pend[N_EVT-1:0] & ~clr_evt) | evt_set;
        // condition sources track their condition
        state_d.pend[NS-1:N_EVT] = lvl_src;
        if (en_wr) state_d.en = en_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign pend   = state_q.pend;
    assign enable = state_q.en;
    assign masked = state_q.pend & state_q.en;
    assign irq    = |masked;

    logic unused_clr;
    assign unused_clr = ^clr_wdata[NS-1:N_EVT];

endmodule

// File: rtl/xfer_fifo_irq.sv
module xfer_fifo_irq
    import xfer_fifo_pkg::*;
#(
    parameter int TX_DEPTH = 64,
    parameter int RX_DEPTH = 64,
    parameter int DATA_W   = 8,
    parameter int CMD_W    = 11,
    parameter int REG_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [CMD_W-1:0]  seq_tx_cmd,
    output logic              seq_tx_valid,
    input  logic              seq_tx_pop,
    input  logic              seq_rx_push,
    input  logic [DATA_W-1:0] seq_rx_data,
    input  logic              seq_done,
    input  logic              seq_err,
    output logic              irq
);
    localparam int TX_LW  = $clog2(TX_DEPTH) + 1;
    localparam int RX_LW  = $clog2(RX_DEPTH) + 1;
    localparam int FCTL_W = $bits(fctl_t);

    typedef struct packed {
        fctl_t fctl;
    } top_st_t;

    top_st_t state_d, state_q;
    reg_addr_e ra;

    logic              wr_cmd, wr_fctl, wr_ien, wr_iclr, rd_rxd;
    logic [TX_LW-1:0]  tx_level;
    logic [RX_LW-1:0]  rx_level;
    logic              tx_empty_w, tx_full_w, tx_rerr_w, tx_werr_w;
    logic              rx_empty_w, rx_full_w, rx_rerr_w, rx_werr_w;
    logic [DATA_W-1:0] rx_head;
    logic              tx_flush, rx_flush;
    logic              tx_low, rx_high, fifo_err;
    logic [N_SRC-1:0]  pend_w, ien_w, imsk_w;

    assign ra      = reg_addr_e'(reg_addr);
    assign wr_cmd  = reg_wr_en && (ra == RA_CMD);
    assign wr_fctl = reg_wr_en && (ra == RA_FCTL);
    assign wr_ien  = reg_wr_en && (ra == RA_IEN);
    assign wr_iclr = reg_wr_en && (ra == RA_ICLR);
    assign rd_rxd  = reg_rd_en && (ra == RA_RXD);

    always_comb begin
        state_d = state_q;
        if (wr_fctl) state_d.fctl = fctl_t'(reg_wdata[FCTL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.fctl.tx_thr   <= THR_W'(RST_TX_THR);
            state_q.fctl.rx_thr   <= THR_W'(RST_RX_THR);
            state_q.fctl.tx_flush <= 1'b0;
            state_q.fctl.rx_flush <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign tx_flush = state_q.fctl.tx_flush;
    assign rx_flush = state_q.fctl.rx_flush;

    xfer_fifo_buf #(.DEPTH(TX_DEPTH), .WIDTH(CMD_W)) tx_buf_i (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .wr_en(wr_cmd), .wr_data(reg_wdata[CMD_W-1:0]),
        .rd_en(seq_tx_pop), .rd_data(seq_tx_cmd),
        .level(tx_level), .empty(tx_empty_w), .full(tx_full_w),
        .rd_err(tx_rerr_w), .wr_err(tx_werr_w)
    );

    xfer_fifo_buf #(.DEPTH(RX_DEPTH), .WIDTH(DATA_W)) rx_buf_i (
        .clk(clk), .rst_n(rst_n), .flush(rx_flush),
        .wr_en(seq_rx_push), .wr_data(seq_rx_data),
        .rd_en(rd_rxd), .rd_data(rx_head),
        .level(rx_level), .empty(rx_empty_w), .full(rx_full_w),
        .rd_err(rx_rerr_w), .wr_err(rx_werr_w)
    );

    assign seq_tx_valid = !tx_empty_w;
    assign tx_low   = (tx_level <= TX_LW'(state_q.fctl.tx_thr));
    assign rx_high  = (rx_level >= RX_LW'(state_q.fctl.rx_thr));
    assign fifo_err = tx_rerr_w | tx_werr_w | rx_rerr_w | rx_werr_w;

    xfer_irq_ctrl #(.N_EVT(N_EVT), .N_LVL(N_LVL)) irq_i (
        .clk(clk), .rst_n(rst_n),
        .evt_set({seq_err, seq_done}),
        .lvl_src({tx_low, rx_high, fifo_err}),
        .en_wr(wr_ien), .en_wdata(reg_wdata[N_SRC-1:0]),
        .clr_wr(wr_iclr), .clr_wdata(reg_wdata[N_SRC-1:0]),
        .pend(pend_w), .enable(ien_w), .masked(imsk_w), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (ra)
            RA_RXD:  reg_rdata[DATA_W-1:0] = rx_head;
            RA_FCTL: reg_rdata[FCTL_W-1:0] = state_q.fctl;
            RA_FSTAT: begin
                reg_rdata[0]  = rx_rerr_w;
                reg_rdata[1]  = rx_werr_w;
                reg_rdata[3]  = rx_empty_w;
                reg_rdata[6]  = tx_rerr_w;
                reg_rdata[7]  = tx_werr_w;
                reg_rdata[11] = tx_full_w;
            end
            RA_IEN:  reg_rdata[N_SRC-1:0] = ien_w;
            RA_IMSK: reg_rdata[N_SRC-1:0] = imsk_w;
            RA_IRAW: reg_rdata[N_SRC-1:0] = pend_w;
            default: reg_rdata = '0;
        endcase
    end

    logic unused_bits;
    assign unused_bits = ^{reg_wdata, rx_full_w};

endmodule

// File: rtl/xfer_fifo_irq_chk.sv
module xfer_fifo_irq_chk
    import xfer_fifo_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic              reg_rd_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              seq_tx_pop,
    input logic              seq_done,
    input logic              tx_full_w,
    input logic              tx_empty_w,
    input logic              rx_empty_w,
    input logic              rx_rerr_w,
    input logic              tx_flush,
    input logic              rx_flush,
    input logic [N_SRC-1:0]  pend_w,
    input logic [N_SRC-1:0]  ien_w,
    input logic              irq
);
    // R4: a command write into a full buffer without a pop keeps it full
    assert_tx_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full_w && reg_wr_en && reg_addr == RA_CMD && !seq_tx_pop && !tx_flush)
        |=> tx_full_w);

    // R4: popping an empty receive buffer raises its read-error flag
    assert_rx_underflow_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_empty_w && reg_rd_en && reg_addr == RA_RXD && !rx_flush) |=> rx_rerr_w);

    // R5: an active flush leaves the buffer empty on the next cycle
    assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> tx_empty_w);

    // R7: a done pulse latches pending bit 0
    assert_done_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> pend_w[0]);

    // R8: bit 0 stays pending unless a clear names it
    assert_done_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_w[0] && !(reg_wr_en && reg_addr == RA_ICLR && reg_wdata[0])) |=> pend_w[0]);

    // R9: with every source disabled the line stays low
    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_w == '0) |-> !irq);

    // R10: a buffer error flag makes the FIFO-error source pending
    assert_fifo_err_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rerr_w |=> pend_w[2]);

endmodule

bind xfer_fifo_irq xfer_fifo_irq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .seq_tx_pop(seq_tx_pop),
    .seq_done(seq_done), .tx_full_w(tx_full_w), .tx_empty_w(tx_empty_w),
    .rx_empty_w(rx_empty_w), .rx_rerr_w(rx_rerr_w), .tx_flush(tx_flush),
    .rx_flush(rx_flush), .pend_w(pend_w), .ien_w(ien_w), .irq(irq)
);

// File: tb/xfer_fifo_irq_tb_top.sv
module xfer_fifo_irq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [10:0] seq_tx_cmd;
    logic        seq_tx_valid;
    logic        seq_tx_pop = 1'b0, seq_rx_push = 1'b0;
    logic [7:0]  seq_rx_data = '0;
    logic        seq_done = 1'b0, seq_err = 1'b0;
    logic        irq;

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    localparam logic [2:0] A_CMD = 0, A_RXD = 1, A_FCTL = 2, A_FSTAT = 3,
                           A_IEN = 4, A_ICLR = 5, A_IMSK = 6, A_IRAW = 7;
    localparam int TXT = 20, RXT = 10;
    localparam logic [31:0] FCTL_RUN = (TXT << 8) | (RXT << 2);

    always #10 clk = ~clk;

    xfer_fifo_irq dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .seq_tx_cmd(seq_tx_cmd), .seq_tx_valid(seq_tx_valid), .seq_tx_pop(seq_tx_pop),
        .seq_rx_push(seq_rx_push), .seq_rx_data(seq_rx_data), .seq_done(seq_done),
        .seq_err(seq_err), .irq(irq)
    );

    function automatic logic [10:0] tx_val(input int i);
        return 11'((i * 37 + 5) % 2048);
    endfunction
    function automatic logic [7:0] rx_val(input int i);
        return 8'((i * 29 + 3) % 256);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk); reg_wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk); reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic rx_read(output logic [31:0] v);
        @(negedge clk); reg_addr = A_RXD; #1; v = reg_rdata; reg_rd_en = 1'b1;
        @(negedge clk); reg_rd_en = 1'b0;
    endtask

    task automatic tx_take(output logic [10:0] v, output logic vld);
        @(negedge clk); #1; v = seq_tx_cmd; vld = seq_tx_valid; seq_tx_pop = 1'b1;
        @(negedge clk); seq_tx_pop = 1'b0;
    endtask

    task automatic rx_put(input logic [7:0] d);
        @(negedge clk); seq_rx_data = d; seq_rx_push = 1'b1;
        @(negedge clk); seq_rx_push = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [10:0] c;
        logic vld;

        // R1: reset values
        repeat (3) @(negedge clk);
        check("R1 irq in reset", 32'(irq), 0);
        rst_n = 1'b1;
        peek(A_FCTL, v);  check("R1 fctl", v, 32'h1F0);
        peek(A_FSTAT, v); check("R1 fstat", v, 32'h008);
        peek(A_IEN, v);   check("R1 ien", v, 0);
        peek(A_IRAW, v);  check("R6 tx low at reset", v, 32'h10);
        check("R1 irq", 32'(irq), 0);

        // R11: program thresholds
        wr(A_FCTL, FCTL_RUN);
        peek(A_FCTL, v); check("R11 fctl readback", v, FCTL_RUN);

        // R2/R3/R6: fill transmit buffer one entry at a time
        for (int k = 1; k <= 64; k++) begin
            wr(A_CMD, 32'(tx_val(k - 1)));
            peek(A_IRAW, v);  check("R6 tx threshold", 32'(v[4]), 32'(k <= TXT));
            peek(A_FSTAT, v); check("R3 tx full", 32'(v[11]), 32'(k == 64));
        end
        // R4: overflow write is discarded and flagged
        wr(A_CMD, 32'h7FF);
        peek(A_FSTAT, v); check("R4 tx write error", v & 32'h8C0, 32'h880);
        peek(A_IRAW, v);  check("R10 fifo err pending", 32'(v[2]), 1);
        for (int k = 0; k < 64; k++) begin
            tx_take(c, vld);
            check("R2 tx valid", 32'(vld), 1);
            check("R2 tx order", 32'(c), 32'(tx_val(k)));
            peek(A_IRAW, v); check("R6 tx threshold drain", 32'(v[4]), 32'((63 - k) <= TXT));
        end
        check("R2 tx empty valid", 32'(seq_tx_valid), 0);
        tx_take(c, vld);
        peek(A_FSTAT, v); check("R4 tx read error", 32'(v[6]), 1);

        // R5: transmit flush clears error flags
        wr(A_FCTL, FCTL_RUN | 32'h2);
        peek(A_FCTL, v);  check("R5 flush readback", v, FCTL_RUN | 32'h2);
        peek(A_FSTAT, v); check("R5 tx errors cleared", v & 32'h8C0, 0);
        wr(A_FCTL, FCTL_RUN);

        // R2/R3/R6: receive buffer sweep
        for (int k = 1; k <= 64; k++) begin
            rx_put(rx_val(k - 1));
            peek(A_IRAW, v);  check("R6 rx threshold", 32'(v[3]), 32'(k >= RXT));
            peek(A_FSTAT, v); check("R3 rx not empty", 32'(v[3]), 0);
        end
        rx_put(8'hEE);
        peek(A_FSTAT, v); check("R4 rx write error", 32'(v[1]), 1);
        for (int k = 0; k < 64; k++) begin
            rx_read(v);
            check("R2 rx order", v, 32'(rx_val(k)));
        end
        peek(A_FSTAT, v); check("R3 rx empty", 32'(v[3]), 1);
        rx_read(v);
        peek(A_FSTAT, v); check("R4 rx read error", v & 32'h3, 32'h3);

        // R5: receive flush with data present, push ignored while held
        for (int k = 0; k < 5; k++) rx_put(rx_val(k));
        wr(A_FCTL, FCTL_RUN | 32'h1);
        peek(A_FSTAT, v); check("R5 rx flushed", v, 32'h008);
        rx_put(8'h55);
        peek(A_FSTAT, v); check("R5 push ignored in flush", v, 32'h008);
        wr(A_FCTL, FCTL_RUN);
        peek(A_FSTAT, v); check("R5 rx still empty", v, 32'h008);

        // R8: clear all; condition source re-asserts
        wr(A_ICLR, 32'h1F);
        peek(A_IRAW, v); check("R8 level source survives clear", v, 32'h10);

        // R7: event latching
        @(negedge clk); seq_done = 1'b1; @(negedge clk); seq_done = 1'b0;
        repeat (3) @(negedge clk);
        peek(A_IRAW, v); check("R7 done latched", v, 32'h11);
        @(negedge clk); seq_err = 1'b1; @(negedge clk); seq_err = 1'b0;
        peek(A_IRAW, v); check("R7 err latched", v, 32'h13);
        wr(A_ICLR, 32'h2);
        peek(A_IRAW, v); check("R8 only bit1 cleared", v, 32'h11);
        // event and clear in the same cycle
        @(negedge clk); reg_addr = A_ICLR; reg_wdata = 32'h1; reg_wr_en = 1'b1; seq_done = 1'b1;
        @(negedge clk); reg_wr_en = 1'b0; seq_done = 1'b0;
        peek(A_IRAW, v); check("R7 set wins over clear", v, 32'h11);

        // R9: sweep every enable pattern against pending 0x11
        for (int e = 0; e < 32; e++) begin
            wr(A_IEN, 32'(e));
            peek(A_IMSK, v);
            check("R9 masked", v, 32'(e) & 32'h11);
            check("R9 irq", 32'(irq), 32'(((e & 32'h11) != 0)));
        end
        wr(A_ICLR, 32'h1);
        wr(A_IEN, 32'h1);
        peek(A_IMSK, v); check("R8 bit0 cleared", v, 0);
        check("R9 irq low", 32'(irq), 0);

        finish_run();
    end
endmodule